// File: doc/BRIEF.md
# Command Mailbox with Argument Word Collector

This block is the command entry point of a storage adapter's register file. Software writes a command code into the command register and then pushes 32-bit argument words into the argument register. The block keeps the words in a small buffer and counts them. Each command code has its own argument length, held in a parameter table. As soon as the buffered word count reaches the length the current command needs, the block raises a one-cycle execute strobe. The strobe carries the command code, and the buffer contents stay on a wide output.

The handler logic outside the block answers on a result input in the same cycle as the strobe. That answer becomes the readable command status on the next edge. A code outside the accepted range is run as the "unknown" entry, code 0. Any command whose table entry is zero runs straight from the command write. Once a command has run, the block returns to code 0 with an empty count. A stray argument write in that idle state therefore runs the unknown entry at once.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, `status_o` is 32'h0000_0000 (succeeded), `exec_valid_o` and `overflow_o` are 0, the current command is code 0 and the word count is 0.
- R2: A command write sets `status_o` to 32'hFFFF_FFFE (waiting for arguments) on the next edge, clears the word count and clears `overflow_o`.
- R3: A command value that is neither 0 nor at least LAST_CODE (default 10) is accepted. Any other 32-bit value selects code 0, which needs zero words and so runs at once with `exec_code_o` = 0.
- R4: An argument write stores `wdata_i` in slot k, where k is the current count, and increments the count. Slot k appears on `exec_args_o[32k+31:32k]`.
- R5: `exec_valid_o` is high for the cycle after the write edge at which the stored word count is greater than or equal to the table entry for the current code, with `exec_code_o` set to that code. A command whose entry is 0 fires on its command write.
- R6: The value on `exec_result_i` while `exec_valid_o` is high becomes `status_o` on the next edge.
- R7: After a command runs, the current code is 0 and the count is 0. The next argument write therefore runs code 0 at once.
- R8: The default table, in words, is: code 1 = 6, code 4 = 5, code 5 = 3, code 7 = 2, code 9 = 7; codes 0, 2, 3, 6 and 8 are 0. The buffer depth DEPTH defaults to 6.
- R9: An argument write that arrives with DEPTH words already buffered is dropped and sets `overflow_o`. The flag stays set until the next command write.
- R10: When a command write and an argument write fall in the same cycle, the command is taken and the argument word is ignored.
- R11: A command write in the cycle in which `exec_valid_o` is high wins over the result: `status_o` becomes 32'hFFFF_FFFE and that result is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr_i | input | 1 | Write strobe for the command register |
| arg_wr_i | input | 1 | Write strobe for the argument register |
| wdata_i | input | 32 | Write data for both registers |
| exec_result_i | input | 32 | Handler result, valid while exec_valid_o is high |
| status_o | output | 32 | Command status register |
| exec_valid_o | output | 1 | One-cycle execute strobe |
| exec_code_o | output | 4 | Code of the command being executed |
| exec_args_o | output | DEPTH*32 | Buffered argument words, slot 0 in the low bits |
| overflow_o | output | 1 | Sticky flag for a dropped argument word |

## Verification
Two pairs of functions can share a cycle. In the first, a command write coincides with an argument write. The bench drives both strobes in one cycle and then checks that the count starts again from zero: the execute strobe comes only after the full argument count, and slot 0 holds the first later word. In the second, a command write lands in the very cycle the execute strobe is high. The bench issues the next command write directly after the last argument write and checks that the status reads "waiting" rather than the handler's result. Around these cases, a sweep over every 4-bit code and two out-of-range values checks the fire cycle, the code, the arguments and the status for each code.

// File: rtl/cmdbox_pkg.sv
// Shared constants for the command mailbox.
// Assumes a 4-bit internal command code and a 4-bit word count per table entry.
package cmdbox_pkg;
    localparam int WORD_W    = 32;
    localparam int CODE_W    = 4;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int NEED_W    = 4;

    localparam logic [WORD_W-1:0] ST_SUCCEEDED = 32'h0000_0000;
    localparam logic [WORD_W-1:0] ST_NEED_MORE = 32'hFFFF_FFFE;

    // Words required per code, code 15 in the top nibble, code 0 in the bottom.
    localparam logic [NUM_CODES*NEED_W-1:0] DEFAULT_NEED = 64'h0000_0070_2035_0060;
endpackage

// File: rtl/cmdbox_need_lookup.sv
// Required-word lookup: returns the table entry for a command code.
// Assumes the table is a packed vector of NUM_CODES entries of NEED_W bits each.
module cmdbox_need_lookup #(
    parameter int NUM_CODES = 16,
    parameter int CODE_W    = 4,
    parameter int NEED_W    = 4,
    parameter logic [NUM_CODES*NEED_W-1:0] NEED_TBL = '0
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [NEED_W-1:0] need_o
);
    logic [NEED_W-1:0] entry [NUM_CODES];

    // Unpack the table once per code.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_entry
        assign entry[g] = NEED_TBL[g*NEED_W +: NEED_W];
    end

    // Select the entry for the requested code.
    assign need_o = entry[code_i];
endmodule

// File: rtl/cmdbox_collector.sv
// Argument word buffer and counter.
// A write stores at the current count unless the buffer is full. A full-buffer
// write is dropped and sets a sticky flag. clr_i zeroes the count in the same
// edge as a store. Assumes the caller never asserts wr_i together with a command write.
module cmdbox_collector #(
    parameter int DEPTH  = 6,
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [WORD_W-1:0]     wdata_i,
    input  logic                  clr_i,
    input  logic                  ovf_clr_i,
    output logic [CNT_W-1:0]      cnt_next_o,
    output logic [DEPTH*WORD_W-1:0] args_o,
    output logic                  ovf_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             full;
    logic             store;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign store = wr_i && !full;

    // Count as it would be after this write, before any clear.
    assign cnt_next_o = store ? cnt_q + 1'b1 : cnt_q;

    // Counter: clear wins, otherwise it follows the store.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else            cnt_q <= cnt_next_o;
    end

    // Buffer slots: each slot loads when the count points at it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                args_o[g*WORD_W +: WORD_W] <= '0;
            else if (store && cnt_q == CNT_W'(g))
                args_o[g*WORD_W +: WORD_W] <= wdata_i;
        end
    end

    // Sticky drop flag, cleared by a command write.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovf_o <= 1'b0;
        else if (ovf_clr_i)      ovf_o <= 1'b0;
        else if (wr_i && full)   ovf_o <= 1'b1;
    end

    // R4: a stored word advances the count by one.
    a_r4_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !full && !clr_i) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R9: a dropped word leaves the buffer full.
    a_r9_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && full && !clr_i) |=> full);
endmodule

// File: rtl/cmdbox_status.sv
// Command status register.
// A command write loads "waiting for arguments" and wins over a handler result
// arriving in the same cycle.
module cmdbox_status #(
    parameter int WORD_W = 32,
    parameter logic [WORD_W-1:0] RESET_VAL   = '0,
    parameter logic [WORD_W-1:0] PENDING_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending_i,
    input  logic              res_valid_i,
    input  logic [WORD_W-1:0] res_i,
    output logic [WORD_W-1:0] status_o
);
    // Update status: reset, then pending, then result.
    always_ff @(posedge clk) begin
        if (!rst_n)           status_o <= RESET_VAL;
        else if (pending_i)   status_o <= PENDING_VAL;
        else if (res_valid_i) status_o <= res_i;
    end

    // R6: a result with no competing command write becomes the status.
    a_r6_result_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && !pending_i) |=> status_o == $past(res_i));

    // R11: a command write overrides a result in the same cycle.
    a_r11_cmd_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && pending_i) |=> status_o == PENDING_VAL);
endmodule

// File: rtl/cmd_mailbox.sv
// Command mailbox top.
// Decodes the command write, tracks the current code, decides when enough
// argument words have arrived, pulses the execute strobe and routes the
// handler's result into the status register. Assumes the handler drives
// exec_result_i combinationally while exec_valid_o is high.
module cmd_mailbox
    import cmdbox_pkg::*;
#(
    parameter int DEPTH     = 6,
    parameter int LAST_CODE = 10,
    parameter logic [NUM_CODES*NEED_W-1:0] NEED_TBL = DEFAULT_NEED
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_wr_i,
    input  logic                    arg_wr_i,
    input  logic [WORD_W-1:0]       wdata_i,
    input  logic [WORD_W-1:0]       exec_result_i,
    output logic [WORD_W-1:0]       status_o,
    output logic                    exec_valid_o,
    output logic [CODE_W-1:0]       exec_code_o,
    output logic [DEPTH*WORD_W-1:0] exec_args_o,
    output logic                    overflow_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CODE_W-1:0] cur_q;
    logic [CODE_W-1:0] sel_code;
    logic [NEED_W-1:0] need;
    logic [CNT_W-1:0]  cnt_next;
    logic              code_ok;
    logic              arg_wr;
    logic              fire;
    logic [31:0]       words_now;

    // A command write takes the cycle, so a same-cycle argument write is ignored.
    assign arg_wr  = arg_wr_i && !cmd_wr_i;
    assign code_ok = (wdata_i != '0) && (wdata_i < WORD_W'(LAST_CODE));

    // Code under evaluation: the new command on a command write, else the current one.
    always_comb begin
        if (cmd_wr_i) sel_code = code_ok ? wdata_i[CODE_W-1:0] : '0;
        else          sel_code = cur_q;
    end

    cmdbox_need_lookup #(
        .NUM_CODES (NUM_CODES),
        .CODE_W    (CODE_W),
        .NEED_W    (NEED_W),
        .NEED_TBL  (NEED_TBL)
    ) u_need (
        .code_i (sel_code),
        .need_o (need)
    );

    // Words counted after this edge's write; a command write restarts at zero.
    assign words_now = cmd_wr_i ? 32'd0 : 32'(cnt_next);
    assign fire      = (cmd_wr_i || arg_wr) && (words_now >= 32'(need));

    cmdbox_collector #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) u_coll (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (arg_wr),
        .wdata_i    (wdata_i),
        .clr_i      (cmd_wr_i || fire),
        .ovf_clr_i  (cmd_wr_i),
        .cnt_next_o (cnt_next),
        .args_o     (exec_args_o),
        .ovf_o      (overflow_o)
    );

    // Current command: back to code 0 after firing, else load on a command write.
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_q <= '0;
        else if (fire)     cur_q <= '0;
        else if (cmd_wr_i) cur_q <= sel_code;
    end

    // Execute strobe and the code it carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_valid_o <= 1'b0;
            exec_code_o  <= '0;
        end else begin
            exec_valid_o <= fire;
            if (fire) exec_code_o <= sel_code;
        end
    end

    cmdbox_status #(
        .WORD_W      (WORD_W),
        .RESET_VAL   (ST_SUCCEEDED),
        .PENDING_VAL (ST_NEED_MORE)
    ) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending_i   (cmd_wr_i),
        .res_valid_i (exec_valid_o),
        .res_i       (exec_result_i),
        .status_o    (status_o)
    );

    // R2: a command write leaves the status waiting for arguments.
    a_r2_cmd_pending: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_i |=> status_o == ST_NEED_MORE);

    // R5: the execute strobe only follows a register write.
    a_r5_exec_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid_o |-> $past(cmd_wr_i || arg_wr_i));

    // R9: the drop flag holds until a command write.
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !cmd_wr_i) |=> overflow_o);

    // R2: a command write clears the drop flag.
    a_r2_ovf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_i |=> !overflow_o);
endmodule

// File: tb/tb_cmd_mailbox.sv
`timescale 1ns/1ps
module tb_cmd_mailbox;
    localparam int DEPTH = 6;
    localparam int LAST  = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_wr, arg_wr;
    logic [31:0]       wdata;
    logic [31:0]       exec_result;
    logic [31:0]       status;
    logic              exec_valid;
    logic [3:0]        exec_code;
    logic [DEPTH*32-1:0] exec_args;
    logic              ovf;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmd_mailbox dut (
        .clk (clk), .rst_n (rst_n), .cmd_wr_i (cmd_wr), .arg_wr_i (arg_wr),
        .wdata_i (wdata), .exec_result_i (exec_result), .status_o (status),
        .exec_valid_o (exec_valid), .exec_code_o (exec_code),
        .exec_args_o (exec_args), .overflow_o (ovf)
    );

    // Handler model: result is a tagged copy of the code.
    always_comb exec_result = 32'hC0DE_0000 | 32'(exec_code);

    function automatic logic [31:0] res_of(int c);
        return 32'hC0DE_0000 | 32'(c);
    endfunction

    // Required words per code, per R8.
    function automatic int need_of(int c);
        case (c)
            1: return 6;
            4: return 5;
            5: return 3;
            7: return 2;
            9: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] pat(int c, int k);
        return 32'hA000_0000 | (32'(c) << 16) | (32'(k) << 8) | 32'h5A;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Tasks start at a negedge and end at the next one.
    task automatic do_cmd(logic [31:0] v);
        cmd_wr = 1'b1; wdata = v;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic do_arg(logic [31:0] v);
        arg_wr = 1'b1; wdata = v;
        @(negedge clk);
        arg_wr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] vals [18];
        rst_n = 1'b0; cmd_wr = 1'b0; arg_wr = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check("R1 status", status, 32'h0);
        check("R1 exec_valid", 32'(exec_valid), 32'd0);
        check("R1 overflow", 32'(ovf), 32'd0);

        // R1/R7: idle argument write runs code 0 at once.
        do_arg(32'h1111_0000);
        check("R7 idle fire", 32'(exec_valid), 32'd1);
        check("R7 idle code", 32'(exec_code), 32'd0);
        check("R4 idle slot0", exec_args[31:0], 32'h1111_0000);
        @(negedge clk);
        check("R6 idle result", status, res_of(0));

        // Sweep every 4-bit code plus two out-of-range values (R3, R5, R8).
        for (int i = 0; i < 16; i++) vals[i] = 32'(i);
        vals[16] = 32'h0001_0001;
        vals[17] = 32'hFFFF_FFFF;
        for (int i = 0; i < 18; i++) begin
            automatic logic [31:0] v = vals[i];
            automatic bit ok = (v != 0) && (v < LAST);
            automatic int c = ok ? int'(v) : 0;
            automatic int n = ok ? need_of(c) : 0;
            do_cmd(v);
            check("R2 pending", status, 32'hFFFF_FFFE);
            check("R2 ovf cleared", 32'(ovf), 32'd0);
            if (n == 0) begin
                check("R3 zero-need fire", 32'(exec_valid), 32'd1);
            end else begin
                check("R5 no early fire", 32'(exec_valid), 32'd0);
                for (int k = 0; k < n; k++) begin
                    do_arg(pat(c, k));
                    check("R8 fire at need", 32'(exec_valid),
                          32'((k == n - 1) && (n <= DEPTH)));
                    if (k >= DEPTH) check("R9 overflow set", 32'(ovf), 32'd1);
                end
            end
            if (n <= DEPTH) begin
                check("R5 exec code", 32'(exec_code), 32'(c));
                for (int k = 0; k < n; k++)
                    check("R4 arg slot", exec_args[k*32 +: 32], pat(c, k));
                @(negedge clk);
                check("R6 status result", status, res_of(c));
                check("R5 one-cycle strobe", 32'(exec_valid), 32'd0);
                do_arg(pat(15, 15));
                check("R7 revert fire", 32'(exec_valid), 32'd1);
                check("R7 revert code", 32'(exec_code), 32'd0);
                @(negedge clk);
            end else begin
                @(negedge clk);
                check("R9 no exec when oversize", status, 32'hFFFF_FFFE);
                check("R9 overflow sticky", 32'(ovf), 32'd1);
            end
        end

        // R10: command and argument in one cycle, the argument is ignored.
        cmd_wr = 1'b1; arg_wr = 1'b1; wdata = 32'd1;
        @(negedge clk);
        cmd_wr = 1'b0; arg_wr = 1'b0;
        for (int k = 0; k < 6; k++) begin
            do_arg(pat(1, k + 8));
            check("R10 fire only at sixth", 32'(exec_valid), 32'(k == 5));
        end
        check("R10 slot0 is later word", exec_args[31:0], pat(1, 8));
        @(negedge clk);

        // R11: command write in the execute cycle wins over the result.
        do_cmd(32'd5);
        for (int k = 0; k < 3; k++) do_arg(pat(5, k));
        check("R11 exec high", 32'(exec_valid), 32'd1);
        do_cmd(32'd4);
        check("R11 pending wins", status, 32'hFFFF_FFFE);
        check("R11 no new exec", 32'(exec_valid), 32'd0);
        for (int k = 0; k < 5; k++) do_arg(pat(4, k));
        check("R11 next cmd fires", 32'(exec_code), 32'd4);
        @(negedge clk);
        check("R11 next result", status, res_of(4));

        // R9: overflow cleared by a command write.
        do_cmd(32'd9);
        for (int k = 0; k < 7; k++) do_arg(pat(9, k));
        check("R9 flag after drop", 32'(ovf), 32'd1);
        do_cmd(32'd2);
        check("R9 flag cleared", 32'(ovf), 32'd0);
        check("R9 code 2 fires", 32'(exec_code), 32'd2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule